// File: doc/BRIEF.md
# Prescaled 9-bit PWM Channel

This block produces one pulse-width-modulated output whose period is built from three selectors applied to a slow reference: a choice among three reference clock-enable streams, a non-binary pre-divider of 1, 3, 5 or 6, and a binary divider of 2^M. Every 2^M-th pre-divider overflow advances a 9-bit period counter, so one period always spans 512 such ticks. The output is high while the count is below the programmed duty value.

Software programs the channel through a byte-wide write port. Writes to the clock select, prescale and duty registers are held in staging registers. They reach the running counter only after a sync write. An optional glitch-removal mode defers that hand-over to the next period boundary, so no period is ever cut short or stretched by a mix of old and new settings. The output enable, duty-source select and output-buffer enable act at once.

All reference clocks arrive as single-cycle enable pulses in the system clock domain. The block has no ramp generator, so selecting the ramp as duty source yields a low output.

Top module: `pwm_prescaled_channel`

## Requirements
- R1: After reset, pwmOut and pwmOe are 0, and no reference is selected, so the output stays low until a sync write makes settings active.
- R2: One period lasts 512 × ratio × 2^M selected reference pulses. The ratio comes from prescale register (address 1) bits 6:5, where 0, 1, 2, 3 give 1, 3, 5, 6. M comes from bits 2:0. The period counter wraps from 511 to 0 and advances only on selected reference pulses.
- R3: The output is high for exactly duty ticks of each period. The duty is 9 bits: address 2 holds bits 7:0 and bit 0 of address 3 holds bit 8. Duty 0 never drives high, and duty 511 drives high for all but one tick.
- R4: Clock select (address 0, bits 1:0) picks no clock for 0, and refTick[0], refTick[1] or refTick[2] for 1, 2 or 3. With 0 selected, the counters hold at zero and the output is low.
- R5: Writes to addresses 0 to 3 change nothing at the output until 1 is written to bit 0 of address 5 (sync). A sync write with bit 0 clear does nothing.
- R6: With glitch removal off (address 6 bit 5 = 0), staged settings become active on the clock edge after the sync write, and a fresh period starts at count 0.
- R7: With glitch removal on (address 6 bit 5 = 1), a pending sync is applied only when the period counter wraps, or at once if the channel is not running. Until then the old settings keep driving the output.
- R8: Control register (address 4) bit 7 enables the output. While it is 0, the output is low and the counters are held at zero. Setting it starts a period at count 0 on the next cycle.
- R9: Control bit 2 selects the duty register as the duty source. With bit 2 clear, the output is low. Bit 1 (ramp source) has no effect on the output.
- R10: pwmOe follows control bit 5 from the cycle after the write, whatever the PWM state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register address |
| wrData | input | 8 | Register write data |
| refTick | input | 3 | Reference clock-enable pulses, one per selectable reference |
| pwmOut | output | 1 | PWM output |
| pwmOe | output | 1 | Output buffer enable |

## Verification
Duty is tested with measurement windows of exactly one period, which makes the high-cycle count independent of phase. Random mixes of reference, pre-divider, exponent and duty are run this way, along with the duty extremes 0 and 511. Because each reference stream pulses at a different rate, a wrong clock-select mapping changes the measured counts. The sync timing is tested by changing the duty just after a falling edge. With glitch removal off, the output rises on the next cycle and the full new duty follows. With glitch removal on, the output stays low until the wrap, which tells the two apply paths apart. Gating is checked separately for the enable bit, the duty-source bit, clock select 0 and the buffer enable, each observed on the pins.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
  localparam int SEL_W   = 2;
  localparam int PRE_W   = 2;
  localparam int EXP_W   = 3;
  localparam int DUTY_W  = 9;
  localparam int NUM_REF = (1 << SEL_W) - 1;
  localparam int PRE_CNT_W = 3;
  localparam int EXP_CNT_W = (1 << EXP_W) - 1;

  localparam int REG_CLKSEL  = 0;
  localparam int REG_PRESCL  = 1;
  localparam int REG_DUTYLO  = 2;
  localparam int REG_DUTYHI  = 3;
  localparam int REG_CTRL    = 4;
  localparam int REG_SYNC    = 5;
  localparam int REG_TYPECFG = 6;

  typedef struct packed {
    logic [SEL_W-1:0]  clkSel;
    logic [PRE_W-1:0]  preSel;
    logic [EXP_W-1:0]  expSel;
    logic [DUTY_W-1:0] duty;
  } chanCfg_t;

  typedef struct packed {
    logic apply;
  } chanStb_t;

  function automatic logic [PRE_CNT_W-1:0] preLimit(input logic [PRE_W-1:0] sel);
    case (sel)
      2'd0:    preLimit = 3'd0;
      2'd1:    preLimit = 3'd2;
      2'd2:    preLimit = 3'd4;
      default: preLimit = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/pwmch_ctrl.sv
module pwmch_ctrl
  import pwmch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              running,
  input  logic              periodEnd,
  output chanCfg_t          stagedCfg,
  output chanStb_t          stb,
  output logic              outEn,
  output logic              srcPwm,
  output logic              bufEn
);
  logic glitchEn;
  logic pending;
  logic syncHit;
  logic applyNow;

  assign syncHit  = wrEn && (wrAddr == ADDR_W'(REG_SYNC)) && wrData[0];
  assign applyNow = pending && (!glitchEn || !running || periodEnd);
  assign stb.apply = applyNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedCfg <= '0;
      outEn     <= 1'b0;
      srcPwm    <= 1'b0;
      bufEn     <= 1'b0;
      glitchEn  <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(REG_CLKSEL):  stagedCfg.clkSel <= wrData[SEL_W-1:0];
        ADDR_W'(REG_PRESCL): begin
          stagedCfg.preSel <= wrData[6:5];
          stagedCfg.expSel <= wrData[2:0];
        end
        ADDR_W'(REG_DUTYLO):  stagedCfg.duty[7:0] <= wrData;
        ADDR_W'(REG_DUTYHI):  stagedCfg.duty[8]   <= wrData[0];
        ADDR_W'(REG_CTRL): begin
          outEn  <= wrData[7];
          bufEn  <= wrData[5];
          srcPwm <= wrData[2];
        end
        ADDR_W'(REG_TYPECFG): glitchEn <= wrData[5];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= syncHit | (pending & ~applyNow);
  end

  // R5: a sync write always leaves a pending transfer behind
  p_sync_pend_r5: assert property (@(posedge clk) disable iff (!rstN)
    syncHit |=> pending);

  // R7: with glitch removal on, a running channel keeps waiting for the wrap
  p_glitch_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pending && glitchEn && running && !periodEnd) |=> pending);

  // R6: an applied transfer is consumed unless a new sync arrives
  p_apply_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (applyNow && !syncHit) |=> !pending);
endmodule

// File: rtl/pwmch_datapath.sv
module pwmch_datapath
  import pwmch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] refTick,
  input  chanCfg_t           stagedCfg,
  input  chanStb_t           stb,
  input  logic               outEn,
  input  logic               srcPwm,
  output logic               pwmOut,
  output logic               running,
  output logic               periodEnd
);
  chanCfg_t               actCfg;
  logic [PRE_CNT_W-1:0]   preCnt;
  logic [EXP_CNT_W-1:0]   expCnt;
  logic [DUTY_W-1:0]      periodCnt;
  logic [NUM_REF:0]       refVec;
  logic                   refPulse;
  logic [PRE_CNT_W-1:0]   preMax;
  logic [EXP_CNT_W-1:0]   expMax;
  logic                   preWrap;
  logic                   expWrap;

  // select 0 maps to a tied-low slot, selects 1..N to the reference pulses
  assign refVec[0] = 1'b0;
  for (genvar gi = 0; gi < NUM_REF; gi++) begin : g_ref
    assign refVec[gi+1] = refTick[gi];
  end

  assign refPulse = refVec[actCfg.clkSel];
  assign running  = outEn && (actCfg.clkSel != '0);
  assign preMax   = preLimit(actCfg.preSel);
  assign expMax   = EXP_CNT_W'((EXP_CNT_W+1)'(1) << actCfg.expSel) - EXP_CNT_W'(1);
  assign preWrap  = (preCnt == preMax);
  assign expWrap  = (expCnt == expMax);
  assign periodEnd = running && refPulse && preWrap && expWrap && (periodCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg    <= '0;
      preCnt    <= '0;
      expCnt    <= '0;
      periodCnt <= '0;
    end else if (stb.apply) begin
      actCfg    <= stagedCfg;
      preCnt    <= '0;
      expCnt    <= '0;
      periodCnt <= '0;
    end else if (!running) begin
      preCnt    <= '0;
      expCnt    <= '0;
      periodCnt <= '0;
    end else if (refPulse) begin
      if (preWrap) begin
        preCnt <= '0;
        if (expWrap) begin
          expCnt    <= '0;
          periodCnt <= periodCnt + DUTY_W'(1);
        end else begin
          expCnt <= expCnt + EXP_CNT_W'(1);
        end
      end else begin
        preCnt <= preCnt + PRE_CNT_W'(1);
      end
    end
  end

  assign pwmOut = running && srcPwm && (periodCnt < actCfg.duty);

  // R8: an idle channel holds its counters at zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (periodCnt == '0) && (preCnt == '0));

  // R2: the period counter wraps to zero at the end of a period
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (periodCnt == '0));

  // R2: without a selected reference pulse the count does not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && !refPulse && !stb.apply) |=> $stable(periodCnt));
endmodule

// File: rtl/pwm_prescaled_channel.sv
module pwm_prescaled_channel
  import pwmch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [2:0]        refTick,
  output logic              pwmOut,
  output logic              pwmOe
);
  chanCfg_t stagedCfg;
  chanStb_t stb;
  logic     outEn;
  logic     srcPwm;
  logic     running;
  logic     periodEnd;

  pwmch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .running   (running),
    .periodEnd (periodEnd),
    .stagedCfg (stagedCfg),
    .stb       (stb),
    .outEn     (outEn),
    .srcPwm    (srcPwm),
    .bufEn     (pwmOe)
  );

  pwmch_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .refTick   (refTick),
    .stagedCfg (stagedCfg),
    .stb       (stb),
    .outEn     (outEn),
    .srcPwm    (srcPwm),
    .pwmOut    (pwmOut),
    .running   (running),
    .periodEnd (periodEnd)
  );
endmodule

// File: tb/pwm_prescaled_channel_tb.sv
module pwm_prescaled_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] refTick = '0;
  logic       pwmOut;
  logic       pwmOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pwm_prescaled_channel #(.ADDR_W(3)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .refTick(refTick), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // refTick[2] every cycle, refTick[1] every 2nd, refTick[0] every 4th
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      refTick = {1'b1, ph[0], ph[1:0] == 2'd0};
    end
  end

  function automatic int ratioOf(int pre);
    case (pre)
      0: return 1;
      1: return 3;
      2: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int refDiv(int sel);
    case (sel)
      1: return 4;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int tickCycles(int sel, int pre, int ex);
    return ratioOf(pre) * (1 << ex) * refDiv(sel);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setDuty(int d);
    wr(2, d & 8'hFF);
    wr(3, (d >> 8) & 1);
  endtask

  task automatic countHigh(int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwmOut) h++;
    end
  endtask

  task automatic waitLevel(logic lvl, output int ok);
    logic prev;
    ok = 0;
    prev = pwmOut;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (pwmOut == lvl && prev != lvl) begin ok = 1; break; end
      prev = pwmOut;
    end
  endtask

  task automatic runHigh(output int n);
    n = 0;
    while (pwmOut && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, n, ok, w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pwmOut at reset", int'(pwmOut), 0);
    chk("R1 pwmOe at reset", int'(pwmOe), 0);
    rstN = 1'b1;

    // control: enable (bit7), buffer (bit5), duty source (bit2)
    wr(4, 8'hA4);
    chk("R10 pwmOe follows bit 5", int'(pwmOe), 1);
    countHigh(600, h);
    chk("R1 low before first sync", h, 0);

    // R5: staged values not yet active
    wr(0, 3); wr(1, 8'h00); setDuty(200);
    countHigh(600, h);
    chk("R5 no effect without sync", h, 0);
    wr(5, 8'h00);
    countHigh(600, h);
    chk("R5 sync with bit0 clear ignored", h, 0);
    wr(5, 1);
    repeat (4) @(negedge clk);
    countHigh(512, h);
    chk("R3 duty 200 high count", h, 200);

    // R3: duty extremes
    setDuty(0); wr(5, 1); repeat (4) @(negedge clk);
    countHigh(512, h);
    chk("R3 duty 0 never high", h, 0);
    setDuty(511); wr(5, 1); repeat (4) @(negedge clk);
    countHigh(512, h);
    chk("R3 duty 511 high count", h, 511);

    // R2: period length with ratio 3 and M=1 (bits 6:5 = 1, bits 2:0 = 1)
    wr(1, 8'h21); setDuty(256); wr(5, 1);
    waitLevel(1'b1, ok);
    n = 0;
    waitLevel(1'b0, ok);
    n = 0;
    begin
      logic prev;
      prev = pwmOut;
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        n++;
        if (pwmOut && !prev) break;
        prev = pwmOut;
      end
    end
    w = 512 * tickCycles(3, 1, 1);
    // n counts from the sample after the fall to the rise: low part only
    chk("R2 low span ratio3 M1", n, w - 256 * tickCycles(3, 1, 1));
    countHigh(w, h);
    chk("R2 high span ratio3 M1", h, 256 * tickCycles(3, 1, 1));

    // R5: new duty held back until sync
    wr(1, 8'h00); setDuty(300); wr(5, 1); repeat (4) @(negedge clk);
    setDuty(100);
    countHigh(512, h);
    chk("R5 staged duty held back", h, 300);
    wr(5, 1); repeat (4) @(negedge clk);
    countHigh(512, h);
    chk("R5 duty after sync", h, 100);

    // R6: glitch removal off, immediate restart
    waitLevel(1'b0, ok);
    setDuty(400); wr(5, 1);
    @(negedge clk);
    chk("R6 output high right after apply", int'(pwmOut), 1);
    runHigh(n);
    chk("R6 fresh period high run", n, 400);

    // R7: glitch removal on, deferred until wrap
    wr(6, 8'h20);
    waitLevel(1'b0, ok);
    setDuty(50); wr(5, 1);
    countHigh(90, h);
    chk("R7 old period kept to the wrap", h, 0);
    waitLevel(1'b1, ok);
    runHigh(n);
    chk("R7 new duty after wrap", n, 50);
    wr(6, 8'h00);

    // R4: select 0 stops the channel
    wr(0, 0); wr(5, 1);
    countHigh(600, h);
    chk("R4 select 0 output low", h, 0);
    wr(0, 3); setDuty(300); wr(5, 1); repeat (4) @(negedge clk);

    // R8: enable off then on
    wr(4, 8'h24);
    countHigh(600, h);
    chk("R8 disabled output low", h, 0);
    wr(4, 8'hA4);
    chk("R8 restart high at once", int'(pwmOut), 1);
    runHigh(n);
    chk("R8 restart from count 0", n, 300);

    // R9: duty source clear, ramp bit set
    wr(4, 8'hA2);
    countHigh(600, h);
    chk("R9 ramp source gives low output", h, 0);

    // R10: buffer enable off while running
    wr(4, 8'h84);
    chk("R10 pwmOe cleared", int'(pwmOe), 0);
    countHigh(512, h);
    chk("R10 pwm unaffected by buffer bit", h, 300);
    wr(4, 8'hA4);

    // random mixes: R2, R3, R4
    for (int t = 0; t < 5; t++) begin
      int sel, pre, ex, d;
      sel = 1 + int'($urandom % 3);
      pre = int'($urandom % 4);
      ex  = int'($urandom % 3);
      d   = int'($urandom % 512);
      while (ex > 0 && 512 * tickCycles(sel, pre, ex) > 16000) ex--;
      w = 512 * tickCycles(sel, pre, ex);
      wr(0, sel); wr(1, (pre << 5) | ex); setDuty(d); wr(5, 1);
      repeat (8) @(negedge clk);
      countHigh(w, h);
      chk($sformatf("R3 R2 R4 random sel%0d pre%0d m%0d duty%0d", sel, pre, ex, d),
          h, d * tickCycles(sel, pre, ex));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule